// File: doc/BRIEF.md
# Double-Buffered DAC Code and Power-State Controller

This block sits between a serial command front end and a 10-bit voltage DAC core. It holds two code registers: a staging register and the live register that drives the converter. It also holds the output power state. Each cycle in which the front end raises a command strobe, the block decodes a 4-bit command and acts on it together with a 10-bit data word. The command can stage a code, load the live code at once, move the staged code to the live one, wake the output, or put it into one of three power-down terminations.

The block leaves reset with both registers at zero and the output powered down through the 100k pulldown. The output stays powered down until a wake-up command arrives. Power-down does not clear either register, so after a wake-up the converter shows the code it held before. The live code is also presented on a separate readback port for the serial front end.

Top module: `dac_reg_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, the staging register is 0 (a transfer command 0x3 then gives `dac_code` 0), `term_sel` is 2'b11 and `buf_en` is 0.
- R2: Command 0x1 with the strobe writes `cmd_data` into the staging register only; `dac_code` does not change in the next cycle.
- R3: Command 0x2 with the strobe writes `cmd_data` into both registers; `dac_code` shows it in the cycle after the strobe edge.
- R4: Command 0x3 with the strobe copies the staging register into the live register, which shows on `dac_code` after the edge.
- R5: Command 0x4 (wake-up) sets `term_sel` to 2'b00 and `buf_en` to 1. It leaves `dac_code` unchanged, so the code held before power-down returns.
- R6: Commands 0x8, 0x9 and 0xA set `term_sel` to 2'b01 (high impedance), 2'b10 (1k to ground) and 2'b11 (100k to ground). Each clears `buf_en` and keeps both registers.
- R7: Commands 0x1, 0x2 and 0x3 issued while powered down update the registers as usual and leave `term_sel` and `buf_en` unchanged.
- R8: Command 0x0 and every code not listed in R2 to R6 change neither register nor the power state.
- R9: `rb_code` always equals `dac_code`, never the staging register.
- R10: `buf_en` is 1 exactly when `term_sel` is 2'b00.
- R11: With `cmd_valid` low, no register and no power state changes, whatever the values on `cmd_op` and `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command code |
| cmd_data | input | 10 | Code word that goes with the command |
| dac_code | output | 10 | Live code to the converter core |
| buf_en | output | 1 | Output buffer enable |
| term_sel | output | 2 | Output termination: 00 active, 01 high-Z, 10 1k, 11 100k |
| rb_code | output | 10 | Readback of the live code |

## Verification
A corrupted live register shows on `dac_code` and `rb_code` one cycle after the strobe edge that caused it. A corrupted staging register stays hidden until the next transfer command, so the stimulus issues transfers often to keep that delay short. A wrong power state shows at once on `term_sel` and `buf_en`. Power-down and wake-up commands are mixed with loads, so a state machine that drops or reloads the code during power-down shows a wrong code in the cycle right after the wake-up.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
  localparam logic [OP_W-1:0] OP_STAGE = 4'h1;
  localparam logic [OP_W-1:0] OP_LIVE  = 4'h2;
  localparam logic [OP_W-1:0] OP_XFER  = 4'h3;
  localparam logic [OP_W-1:0] OP_WAKE  = 4'h4;
  localparam logic [OP_W-1:0] OP_PD0   = 4'h8;
  localparam logic [OP_W-1:0] OP_PD1   = 4'h9;
  localparam logic [OP_W-1:0] OP_PD2   = 4'hA;

  typedef enum logic [1:0] {
    TERM_ACTIVE = 2'b00,
    TERM_HIZ    = 2'b01,
    TERM_1K     = 2'b10,
    TERM_100K   = 2'b11
  } term_e;

  // power-down mode index (0..2) to termination state
  function automatic term_e pd_to_term(input logic [1:0] mode);
    case (mode)
      2'd0:    pd_to_term = TERM_HIZ;
      2'd1:    pd_to_term = TERM_1K;
      default: pd_to_term = TERM_100K;
    endcase
  endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
(
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  output logic            ev_stage,
  output logic            ev_live,
  output logic            ev_xfer,
  output logic            ev_wake,
  output logic            ev_pd,
  output logic [1:0]      pd_mode
);

  always_comb begin
    ev_stage = 1'b0;
    ev_live  = 1'b0;
    ev_xfer  = 1'b0;
    ev_wake  = 1'b0;
    ev_pd    = 1'b0;
    pd_mode  = 2'd2;
    if (valid) begin
      case (op)
        OP_STAGE: ev_stage = 1'b1;
        OP_LIVE:  ev_live  = 1'b1;
        OP_XFER:  ev_xfer  = 1'b1;
        OP_WAKE:  ev_wake  = 1'b1;
        OP_PD0:   begin ev_pd = 1'b1; pd_mode = 2'd0; end
        OP_PD1:   begin ev_pd = 1'b1; pd_mode = 2'd1; end
        OP_PD2:   begin ev_pd = 1'b1; pd_mode = 2'd2; end
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dacreg_codes.sv
module dacreg_codes #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_stage,
  input  logic              ev_live,
  input  logic              ev_xfer,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] live_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (ev_stage || ev_live) stage_q <= data;
      if (ev_live)             live_q  <= data;
      else if (ev_xfer)        live_q  <= stage_q;
    end
  end

  p_hold_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_stage && !ev_live && !ev_xfer) |=> $stable(live_q) && $stable(stage_q));
  p_live_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_live |=> (live_q == $past(data)) && (stage_q == $past(data)));
  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stage && !ev_live && !ev_xfer) |=> $stable(live_q));
  p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer && !ev_live) |=> live_q == $past(stage_q));

endmodule

// File: rtl/dacreg_power.sv
module dacreg_power
  import dacreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wake,
  input  logic       ev_pd,
  input  logic [1:0] pd_mode,
  output logic [1:0] term_sel,
  output logic       buf_en
);

  term_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= TERM_100K;
    else if (ev_pd)   state_q <= pd_to_term(pd_mode);
    else if (ev_wake) state_q <= TERM_ACTIVE;
  end

  assign term_sel = state_q;
  assign buf_en   = (state_q == TERM_ACTIVE);

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wake && !ev_pd) |=> buf_en);
  p_pd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pd |=> !buf_en && term_sel != 2'b00);
  p_keep_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wake && !ev_pd) |=> $stable(term_sel));

endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] dac_code,
  output logic              buf_en,
  output logic [1:0]        term_sel,
  output logic [DATA_W-1:0] rb_code
);

  logic ev_stage, ev_live, ev_xfer, ev_wake, ev_pd;
  logic [1:0] pd_mode;
  logic [DATA_W-1:0] stage_q, live_q;

  dacreg_decode u_dec (
    .valid(cmd_valid), .op(cmd_op),
    .ev_stage(ev_stage), .ev_live(ev_live), .ev_xfer(ev_xfer),
    .ev_wake(ev_wake), .ev_pd(ev_pd), .pd_mode(pd_mode)
  );

  dacreg_codes #(.DATA_W(DATA_W)) u_codes (
    .clk(clk), .rst_n(rst_n),
    .ev_stage(ev_stage), .ev_live(ev_live), .ev_xfer(ev_xfer),
    .data(cmd_data), .stage_q(stage_q), .live_q(live_q)
  );

  dacreg_power u_pwr (
    .clk(clk), .rst_n(rst_n),
    .ev_wake(ev_wake), .ev_pd(ev_pd), .pd_mode(pd_mode),
    .term_sel(term_sel), .buf_en(buf_en)
  );

  assign dac_code = live_q;
  assign rb_code  = live_q;

  p_buf_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en == (term_sel == 2'b00));
  p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_NOP || cmd_op > OP_PD2 ||
     (cmd_op > OP_WAKE && cmd_op < OP_PD0)))
    |=> $stable(dac_code) && $stable(term_sel));

endmodule

// File: tb/dac_reg_ctrl_tb.sv
module dac_reg_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [9:0] cmd_data = '0;
  logic [9:0] dac_code, rb_code;
  logic       buf_en;
  logic [1:0] term_sel;

  int n_chk = 0;
  int n_bad = 0;

  logic [9:0] m_stage, m_live;
  logic [1:0] m_term;

  always #10 clk = ~clk;

  dac_reg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .dac_code(dac_code), .buf_en(buf_en),
    .term_sel(term_sel), .rb_code(rb_code)
  );

  function automatic string tag_of(input logic v, input logic [3:0] op);
    if (!v) return "R11";
    case (op)
      4'h1: return (m_term == 2'b00) ? "R2" : "R7";
      4'h2: return (m_term == 2'b00) ? "R3" : "R7";
      4'h3: return (m_term == 2'b00) ? "R4" : "R7";
      4'h4: return "R5";
      4'h8, 4'h9, 4'hA: return "R6";
      default: return "R8";
    endcase
  endfunction

  // reference semantics written from the requirements
  task automatic model(input logic v, input logic [3:0] op, input logic [9:0] d);
    if (v) begin
      if (op == 4'h1) m_stage = d;
      else if (op == 4'h2) begin m_stage = d; m_live = d; end
      else if (op == 4'h3) m_live = m_stage;
      else if (op == 4'h4) m_term = 2'b00;
      else if (op == 4'h8) m_term = 2'b01;
      else if (op == 4'h9) m_term = 2'b10;
      else if (op == 4'hA) m_term = 2'b11;
    end
  endtask

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "dac_code", dac_code, m_live);
    check("R9", "rb_code", rb_code, m_live);
    check(tag, "term_sel", term_sel, m_term);
    check("R10", "buf_en", buf_en, (m_term == 2'b00));
  endtask

  task automatic apply(input logic v, input logic [3:0] op, input logic [9:0] d);
    string t;
    t = tag_of(v, op);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    model(v, op, d);
    check_all(t);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] pool [12];
    void'($urandom(1234));
    pool = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'h9, 4'hA, 4'h5, 4'h7, 4'hB, 4'hF};
    m_stage = '0; m_live = '0; m_term = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    apply(1'b1, 4'h3, 10'h0);            // R1 staging register reset to zero
    apply(1'b1, 4'h1, 10'h155);          // R7 stage while down
    apply(1'b1, 4'h3, 10'h0);            // R7 transfer while down
    apply(1'b1, 4'h4, 10'h0);            // R5 wake restores code
    apply(1'b1, 4'h1, 10'h2AA);          // R2 stage only
    apply(1'b0, 4'h2, 10'h3FF);          // R11 strobe low
    apply(1'b1, 4'h3, 10'h0);            // R4 transfer
    apply(1'b1, 4'h2, 10'h3FF);          // R3 direct load
    apply(1'b1, 4'h8, 10'h0);            // R6 high-Z
    apply(1'b1, 4'h2, 10'h001);          // R7 direct load while down
    apply(1'b1, 4'h9, 10'h0);            // R6 1k
    apply(1'b1, 4'hA, 10'h0);            // R6 100k
    apply(1'b1, 4'h4, 10'h0);            // R5 wake with new code
    for (int k = 0; k < 16; k++) apply(1'b1, k[3:0], 10'h2C3); // R8 sweep incl. undefined
    for (int i = 0; i < 600; i++) begin
      logic v;
      v = ($urandom % 8) != 0;
      apply(v, pool[$urandom % 12], 10'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule